// File: doc/BRIEF.md
# UART Interrupt Status and Mask Unit

This block keeps the interrupt bookkeeping of a memory-mapped serial port. From the live receive and transmit FIFO occupancy and two programmable trigger levels it forms a read-only live status word each cycle. The same conditions are folded into a sticky interrupt status word, together with single-cycle event pulses for receive overrun, framing error, parity error, receive timeout, modem status change and transmit overflow. Software clears the sticky word one bit at a time by writing ones.

A mask register selects which sticky bits reach the single level-sensitive interrupt line. The mask can only be changed through a set port and a clear port. A write to the mask's own address has no effect. The FIFOs, the serial framing and the baud generator live outside this block, and only their counts and event pulses come in.

All registers sit on a 16-bit bus with a 3-bit word address. Writes take effect at the clock edge. Reads are combinational from the held state. Each trigger level is as wide as its count, so each FIFO depth must be at least 32 for the reset level to fit.

Top module: `uart_irq_unit`

## Requirements
- R1: The live status word (read at address 4) sets bit 0 when rx_count >= RX level, bit 1 when rx_count is 0, bit 2 when rx_count equals RX_DEPTH, bit 3 when tx_count is 0 and bit 4 when tx_count equals TX_DEPTH. All other bits read 0, except bit 13 (R2).
- R2: The TX-trigger condition (tx_count >= TX level) shows at bit 13 of the live word and sets bit 10 of the sticky word (read at address 0). Bit 13 of the sticky word never sets.
- R3: Every clock, live bits 4:0 are ORed into sticky bits 4:0. A sticky bit stays set after its condition goes away, until software clears it.
- R4: Event pulses set sticky bits as follows: receive overrun bit 5, framing error bit 6, parity error bit 7, receive timeout bit 8, modem status bit 9, transmit overflow bit 12.
- R5: Writing address 1 ORs the written value into the mask. Writing address 2 clears every mask bit written as 1. The mask reads back at address 3.
- R6: A write to the mask address 3 leaves the mask unchanged.
- R7: Writing address 0 clears every sticky bit written as 1 and leaves bits written as 0 unchanged.
- R8: irq is high exactly when the mask AND the sticky word is nonzero.
- R9: While rst_n is low, the mask and the sticky word are 0, irq is 0, and both trigger levels read 32.
- R10: When an event or a status condition sets a sticky bit in the same cycle that a write-one-to-clear clears it, the bit ends up set.
- R11: The live status word is read-only. Writing address 4 changes nothing, and reading it changes no state.
- R12: The RX level (address 5) and TX level (address 6) are written and read back at the width of their count, and the trigger compares of R1 and R2 use the written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_count | input | $clog2(RX_DEPTH+1) | Receive FIFO occupancy |
| tx_count | input | $clog2(TX_DEPTH+1) | Transmit FIFO occupancy |
| ev_rx_overrun | input | 1 | Receive overrun pulse |
| ev_frame_err | input | 1 | Framing error pulse |
| ev_parity_err | input | 1 | Parity error pulse |
| ev_rx_timeout | input | 1 | Receive timeout pulse |
| ev_modem | input | 1 | Modem status change pulse |
| ev_tx_overflow | input | 1 | Transmit overflow pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | 16 | Register read data |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the unit with RX_DEPTH 40 and TX_DEPTH 33. Both counts stay six bits wide, so the reset level of 32 fits, while the full conditions sit only a few counts above the trigger level. A TX depth one above the reset trigger level lets tx_count step through below-trigger, at-trigger and full in three consecutive values. The unequal depths show that each full flag compares against its own depth. Small levels such as 0 and 5 are written to check the at-or-above compare at both ends.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int BUS_W  = 16;
  localparam int ADDR_W = 3;

  // register word addresses
  localparam logic [ADDR_W-1:0] A_IRQ_STAT = 3'd0;
  localparam logic [ADDR_W-1:0] A_IRQ_SET  = 3'd1;
  localparam logic [ADDR_W-1:0] A_IRQ_CLR  = 3'd2;
  localparam logic [ADDR_W-1:0] A_IRQ_MASK = 3'd3;
  localparam logic [ADDR_W-1:0] A_LIVE     = 3'd4;
  localparam logic [ADDR_W-1:0] A_RX_LVL   = 3'd5;
  localparam logic [ADDR_W-1:0] A_TX_LVL   = 3'd6;

  // live status bit positions
  localparam int ST_RX_TRIG  = 0;
  localparam int ST_RX_EMPTY = 1;
  localparam int ST_RX_FULL  = 2;
  localparam int ST_TX_EMPTY = 3;
  localparam int ST_TX_FULL  = 4;
  localparam int ST_TX_TRIG  = 13;
  localparam int ST_FOLD_W   = 5;

  // sticky status bit positions
  localparam int IS_RX_OVR  = 5;
  localparam int IS_FRAME   = 6;
  localparam int IS_PARITY  = 7;
  localparam int IS_TIMEOUT = 8;
  localparam int IS_MODEM   = 9;
  localparam int IS_TX_TRIG = 10;
  localparam int IS_TX_OVF  = 12;

  typedef struct packed {
    logic rx_ovr;
    logic frame;
    logic parity;
    logic timeout;
    logic modem;
    logic tx_ovf;
  } evt_t;

  // live status from counts, depths and levels
  function automatic logic [BUS_W-1:0] live_word(
    input logic [31:0] rxc, input logic [31:0] rxd, input logic [31:0] rxt,
    input logic [31:0] txc, input logic [31:0] txd, input logic [31:0] txt);
    logic [BUS_W-1:0] w;
    w = '0;
    w[ST_RX_TRIG]  = (rxc >= rxt);
    w[ST_RX_EMPTY] = (rxc == 32'd0);
    w[ST_RX_FULL]  = (rxc == rxd);
    w[ST_TX_EMPTY] = (txc == 32'd0);
    w[ST_TX_FULL]  = (txc == txd);
    w[ST_TX_TRIG]  = (txc >= txt);
    return w;
  endfunction

  // sticky set sources: folded live bits, remapped TX trigger, events
  function automatic logic [BUS_W-1:0] sticky_sources(
    input logic [BUS_W-1:0] live, input evt_t ev);
    logic [BUS_W-1:0] s;
    s = '0;
    s[ST_FOLD_W-1:0] = live[ST_FOLD_W-1:0];
    s[IS_TX_TRIG]    = live[ST_TX_TRIG];
    s[IS_RX_OVR]     = ev.rx_ovr;
    s[IS_FRAME]      = ev.frame;
    s[IS_PARITY]     = ev.parity;
    s[IS_TIMEOUT]    = ev.timeout;
    s[IS_MODEM]      = ev.modem;
    s[IS_TX_OVF]     = ev.tx_ovf;
    return s;
  endfunction

  // sticky next value: clear first, then set, so a set is never lost
  function automatic logic [BUS_W-1:0] sticky_next(
    input logic [BUS_W-1:0] cur, input logic [BUS_W-1:0] clr,
    input logic [BUS_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/uart_irq_live.sv
module uart_irq_live
  import uart_irq_pkg::*;
#(
  parameter int RX_DEPTH = 64,
  parameter int TX_DEPTH = 64,
  parameter int RX_CW    = $clog2(RX_DEPTH + 1),
  parameter int TX_CW    = $clog2(TX_DEPTH + 1)
) (
  input  logic [RX_CW-1:0] rx_count,
  input  logic [TX_CW-1:0] tx_count,
  input  logic [RX_CW-1:0] rx_level,
  input  logic [TX_CW-1:0] tx_level,
  output logic [BUS_W-1:0] live_o
);

  always_comb begin
    live_o = live_word(32'(rx_count), 32'(RX_DEPTH), 32'(rx_level),
                       32'(tx_count), 32'(TX_DEPTH), 32'(tx_level));
  end

endmodule

// File: rtl/uart_irq_level.sv
module uart_irq_level #(
  parameter int W   = 7,
  parameter int RST = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= W'(RST);
    else if (we) q <= din;
  end

endmodule

// File: rtl/uart_irq_mask.sv
module uart_irq_mask #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] bits,
  output logic [W-1:0] mask_q
);

  logic [W-1:0] mask_d;

  always_comb begin
    mask_d = mask_q;
    if (set_we)      mask_d = mask_q | bits;
    else if (clr_we) mask_d = mask_q & ~bits;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

endmodule

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] set_vec,
  input  logic [BUS_W-1:0] clr_vec,
  output logic [BUS_W-1:0] isr_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= sticky_next(isr_q, clr_vec, set_vec);
  end

endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
  import uart_irq_pkg::*;
#(
  parameter int RX_DEPTH  = 64,
  parameter int TX_DEPTH  = 64,
  parameter int LEVEL_RST = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [$clog2(RX_DEPTH+1)-1:0]    rx_count,
  input  logic [$clog2(TX_DEPTH+1)-1:0]    tx_count,
  input  logic                             ev_rx_overrun,
  input  logic                             ev_frame_err,
  input  logic                             ev_parity_err,
  input  logic                             ev_rx_timeout,
  input  logic                             ev_modem,
  input  logic                             ev_tx_overflow,
  input  logic                             wr_en,
  input  logic [2:0]                       wr_addr,
  input  logic [15:0]                      wr_data,
  input  logic [2:0]                       rd_addr,
  output logic [15:0]                      rd_data,
  output logic                             irq
);

  localparam int RX_CW = $clog2(RX_DEPTH + 1);
  localparam int TX_CW = $clog2(TX_DEPTH + 1);

  // named write strobes
  logic we_irq_stat, we_irq_set, we_irq_clr, we_rx_lvl, we_tx_lvl;
  assign we_irq_stat = wr_en && (wr_addr == A_IRQ_STAT);
  assign we_irq_set  = wr_en && (wr_addr == A_IRQ_SET);
  assign we_irq_clr  = wr_en && (wr_addr == A_IRQ_CLR);
  assign we_rx_lvl   = wr_en && (wr_addr == A_RX_LVL);
  assign we_tx_lvl   = wr_en && (wr_addr == A_TX_LVL);

  logic [RX_CW-1:0] rx_level_q;
  logic [TX_CW-1:0] tx_level_q;
  logic [BUS_W-1:0] live_w, set_vec, clr_vec, mask_q, isr_q;
  evt_t             evt;

  uart_irq_level #(.W(RX_CW), .RST(LEVEL_RST)) u_rx_level (
    .clk(clk), .rst_n(rst_n), .we(we_rx_lvl),
    .din(wr_data[RX_CW-1:0]), .q(rx_level_q));

  uart_irq_level #(.W(TX_CW), .RST(LEVEL_RST)) u_tx_level (
    .clk(clk), .rst_n(rst_n), .we(we_tx_lvl),
    .din(wr_data[TX_CW-1:0]), .q(tx_level_q));

  uart_irq_live #(.RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)) u_live (
    .rx_count(rx_count), .tx_count(tx_count),
    .rx_level(rx_level_q), .tx_level(tx_level_q), .live_o(live_w));

  always_comb begin
    evt.rx_ovr  = ev_rx_overrun;
    evt.frame   = ev_frame_err;
    evt.parity  = ev_parity_err;
    evt.timeout = ev_rx_timeout;
    evt.modem   = ev_modem;
    evt.tx_ovf  = ev_tx_overflow;
    set_vec     = sticky_sources(live_w, evt);
    clr_vec     = we_irq_stat ? wr_data : '0;
  end

  uart_irq_sticky u_sticky (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .isr_q(isr_q));

  uart_irq_mask #(.W(BUS_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .set_we(we_irq_set), .clr_we(we_irq_clr),
    .bits(wr_data), .mask_q(mask_q));

  assign irq = |(mask_q & isr_q);

  always_comb begin
    case (rd_addr)
      A_IRQ_STAT: rd_data = isr_q;
      A_IRQ_MASK: rd_data = mask_q;
      A_LIVE:     rd_data = live_w;
      A_RX_LVL:   rd_data = BUS_W'(rx_level_q);
      A_TX_LVL:   rd_data = BUS_W'(tx_level_q);
      default:    rd_data = '0;
    endcase
  end

endmodule

// File: rtl/uart_irq_unit_chk.sv
module uart_irq_unit_chk
  import uart_irq_pkg::*;
#(
  parameter int TX_CW = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic [15:0]      wr_data,
  input logic             ev_rx_overrun,
  input logic [TX_CW-1:0] tx_count,
  input logic             irq,
  input logic [BUS_W-1:0] mask_q,
  input logic [BUS_W-1:0] isr_q,
  input logic [TX_CW-1:0] tx_level_q
);

  AST_ENABLE_SETS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_IRQ_SET) |=> ((mask_q & $past(wr_data)) == $past(wr_data))); // R5

  AST_DISABLE_CLEARS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_IRQ_CLR) |=> ((mask_q & $past(wr_data)) == '0)); // R5

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (wr_addr == A_IRQ_SET || wr_addr == A_IRQ_CLR)) |=> $stable(mask_q)); // R6

  AST_STICKY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == A_IRQ_STAT) |=> ((isr_q & $past(isr_q)) == $past(isr_q))); // R3

  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_overrun |=> isr_q[IS_RX_OVR]); // R10

  AST_TX_TRIG_REMAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count >= tx_level_q) |=> (isr_q[IS_TX_TRIG] && !isr_q[ST_TX_TRIG])); // R2

  AST_IRQ_QUIET_NO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq); // R8

endmodule

bind uart_irq_unit uart_irq_unit_chk #(.TX_CW(TX_CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .ev_rx_overrun(ev_rx_overrun), .tx_count(tx_count),
  .irq(irq), .mask_q(mask_q), .isr_q(isr_q), .tx_level_q(tx_level_q));

// File: tb/uart_irq_unit_tb.sv
module uart_irq_unit_tb;

  localparam int RXD = 40;
  localparam int TXD = 33;
  localparam int RCW = $clog2(RXD + 1);
  localparam int TCW = $clog2(TXD + 1);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [RCW-1:0] rx_count = '0;
  logic [TCW-1:0] tx_count = '0;
  logic ev_ovr = 0, ev_frm = 0, ev_par = 0, ev_tmo = 0, ev_mdm = 0, ev_tovf = 0;
  logic           wr_en = 1'b0;
  logic [2:0]     wr_addr = '0;
  logic [15:0]    wr_data = '0;
  logic [2:0]     rd_addr = '0;
  logic [15:0]    rd_data;
  logic           irq;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  uart_irq_unit #(.RX_DEPTH(RXD), .TX_DEPTH(TXD), .LEVEL_RST(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
    .ev_rx_overrun(ev_ovr), .ev_frame_err(ev_frm), .ev_parity_err(ev_par),
    .ev_rx_timeout(ev_tmo), .ev_modem(ev_mdm), .ev_tx_overflow(ev_tovf),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

  // expected live word, written from the requirement text
  function automatic logic [15:0] exp_live(int rc, int tc, int rl, int tl);
    logic [15:0] v = 16'h0000;
    if (rc >= rl)  v = v | 16'h0001;
    if (rc == 0)   v = v | 16'h0002;
    if (rc == RXD) v = v | 16'h0004;
    if (tc == 0)   v = v | 16'h0008;
    if (tc == TXD) v = v | 16'h0010;
    if (tc >= tl)  v = v | 16'h2000;
    return v;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(int idx);
    @(negedge clk);
    case (idx)
      0: ev_ovr = 1'b1;
      1: ev_frm = 1'b1;
      2: ev_par = 1'b1;
      3: ev_tmo = 1'b1;
      4: ev_mdm = 1'b1;
      default: ev_tovf = 1'b1;
    endcase
    @(negedge clk);
    {ev_ovr, ev_frm, ev_par, ev_tmo, ev_mdm, ev_tovf} = '0;
  endtask

  // quiet counts (no condition with levels 32) and an empty sticky word
  task automatic settle_quiet();
    @(negedge clk);
    rx_count = RCW'(10); tx_count = TCW'(10);
    wr(3'd0, 16'hFFFF);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(3'd3, v); chk("R9 mask in reset", v, 16'h0000);
    rd(3'd0, v); chk("R9 sticky in reset", v, 16'h0000);
    rd(3'd5, v); chk("R9 rx level", v, 16'd32);
    rd(3'd6, v); chk("R9 tx level", v, 16'd32);
    chk("R9 irq in reset", 16'(irq), 16'h0000);
  endtask

  task automatic t_live();
    logic [15:0] v;
    int rcs[6] = '{0, 31, 32, 40, 5, 5};
    int tcs[6] = '{0, 0, 0, 0, 32, 33};
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      rx_count = RCW'(rcs[i]); tx_count = TCW'(tcs[i]);
      rd(3'd4, v);
      chk("R1 live word", v, exp_live(rcs[i], tcs[i], 32, 32));
    end
  endtask

  task automatic t_levels();
    logic [15:0] v;
    wr(3'd5, 16'd5);
    rd(3'd5, v); chk("R12 rx level readback", v, 16'd5);
    rx_count = RCW'(5); tx_count = TCW'(10);
    rd(3'd4, v); chk("R12 rx at level", v, exp_live(5, 10, 5, 32));
    rx_count = RCW'(4);
    rd(3'd4, v); chk("R12 rx below level", v, exp_live(4, 10, 5, 32));
    wr(3'd6, 16'd0);
    rd(3'd6, v); chk("R12 tx level readback", v, 16'd0);
    tx_count = TCW'(0);
    rd(3'd4, v); chk("R12 tx level zero", v, exp_live(4, 0, 5, 0));
    wr(3'd5, 16'd32);
    wr(3'd6, 16'd32);
  endtask

  task automatic t_remap();
    logic [15:0] v;
    settle_quiet();
    tx_count = TCW'(32);
    wr(3'd0, 16'hFFFF);
    rd(3'd0, v); chk("R2 tx trigger at sticky bit 10", v, 16'h0400);
    rd(3'd4, v); chk("R2 tx trigger at live bit 13", v, 16'h2000);
  endtask

  task automatic t_sticky();
    logic [15:0] v;
    settle_quiet();
    rd(3'd0, v); chk("R3 sticky empty", v, 16'h0000);
    @(negedge clk); rx_count = RCW'(0);
    @(negedge clk); rx_count = RCW'(10);
    @(negedge clk); @(negedge clk);
    rd(3'd0, v); chk("R3 rx empty stays latched", v, 16'h0002);
  endtask

  task automatic t_events();
    logic [15:0] v;
    int pos[6] = '{5, 6, 7, 8, 9, 12};
    for (int i = 0; i < 6; i++) begin
      settle_quiet();
      pulse(i);
      rd(3'd0, v);
      chk("R4 event bit", v, 16'(1) << pos[i]);
    end
    for (int i = 0; i < 6; i++) pulse(i);
  endtask

  task automatic t_w1c();
    logic [15:0] v;
    wr(3'd0, 16'h0060);
    rd(3'd0, v); chk("R7 clear written ones", v, 16'h1380);
    wr(3'd0, 16'h0000);
    rd(3'd0, v); chk("R7 zeros leave bits", v, 16'h1380);
  endtask

  task automatic t_mask();
    logic [15:0] v;
    wr(3'd1, 16'h00F0);
    rd(3'd3, v); chk("R5 enable sets", v, 16'h00F0);
    wr(3'd1, 16'h0003);
    rd(3'd3, v); chk("R5 enable ors", v, 16'h00F3);
    wr(3'd2, 16'h0030);
    rd(3'd3, v); chk("R5 disable clears", v, 16'h00C3);
    wr(3'd3, 16'hFFFF);
    rd(3'd3, v); chk("R6 direct mask write ignored", v, 16'h00C3);
  endtask

  task automatic t_irq();
    chk("R8 irq mask and sticky overlap", 16'(irq), 16'h0001);
    wr(3'd0, 16'h0080);
    chk("R8 irq low after clear", 16'(irq), 16'h0000);
    @(negedge clk); rx_count = RCW'(0);
    @(negedge clk); rx_count = RCW'(10);
    chk("R8 irq from rx empty", 16'(irq), 16'h0001);
    wr(3'd2, 16'hFFFF);
    chk("R8 irq low with empty mask", 16'(irq), 16'h0000);
    wr(3'd1, 16'h1000);
    pulse(5);
    chk("R8 irq from tx overflow", 16'(irq), 16'h0001);
    wr(3'd2, 16'hFFFF);
  endtask

  task automatic t_set_wins();
    logic [15:0] v;
    settle_quiet();
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 16'h0020; ev_ovr = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; ev_ovr = 1'b0;
    rd(3'd0, v); chk("R10 set wins over clear", v, 16'h0020);
  endtask

  task automatic t_live_ro();
    logic [15:0] v, live0, isr0;
    rd(3'd4, live0);
    rd(3'd0, isr0);
    wr(3'd4, 16'hFFFF);
    rd(3'd4, v); chk("R11 live unchanged by write", v, live0);
    rd(3'd0, v); chk("R11 sticky unchanged by live access", v, isr0);
    rd(3'd3, v); chk("R11 mask unchanged by live write", v, 16'h0000);
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_live();
    t_levels();
    t_remap();
    t_sticky();
    t_events();
    t_w1c();
    t_mask();
    t_irq();
    t_set_wins();
    t_live_ro();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule